// File: doc/BRIEF.md
# Vector Partial-Word Shuffle Unit

This block forms a new vector value by gathering partial words out of two source vectors, `v` and `w`, each `K*32` bits wide. A short control word sets the behaviour. It has three fields: a 2-bit width code, four source-select bits and four 2-bit word indices. Each destination word names its own source vector and its own word index, so words can be reordered, duplicated or interleaved from both inputs in one operation.

The four index groups and the four select bits drive the first four destination words. Every later destination word reuses the controls of the destination word at the same position modulo four. Its source index is advanced by one for each full group of four words before it. Within each field, control group 0 sits in the most significant position.

The result is registered and appears one cycle after a valid strobe. A width code whose word is wider than a quarter of the vector is rejected: the result is zero and an error flag is raised.

Top module: `vshuf`

## Requirements
- R1: While `rst_n` is low, `valid_o`, `err_o` and `result_o` are all zero.
- R2: `valid_o` is high exactly in the cycle after a cycle with `valid_i` high.
- R3: For destination word i in 0..3, the source is `w_i` when `sel_i[3-i]` is 1 and `v_i` when it is 0. The source word index is `idx_i[7-2i -: 2]`. Control group 0 therefore sits in the top bits of each field.
- R4: For destination word i of 4 or more, with g = i mod 4, the source is picked by `sel_i[3-g]`. The source word index is `idx_i[7-2g -: 2] + i/4`.
- R5: The width code `wcode_i` selects the word size: 0 gives 8 bits, 1 gives 16 bits, 2 gives 32 bits and 3 gives 64 bits. Words are numbered from bit 0 upward.
- R6: A width code whose word is wider than `K*32/4` bits gives `result_o` = 0 and `err_o` = 1. A code within that limit gives `err_o` = 0.
- R7: In a cycle with `valid_i` low, `result_o` and `err_o` keep their values, whatever the other inputs do.
- R8: With K = 4, 16-bit words, `idx_i` = 8'b10_11_01_10 and `sel_i` = 4'b0011, the result bits 31:0 equal `v_i[63:32]` and the result bits 63:32 equal `w_i[47:16]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Strobe; operands and control are captured this cycle |
| wcode_i | input | 2 | Word width code |
| sel_i | input | 4 | Source-select bits, group 0 in bit 3 |
| idx_i | input | 8 | Four 2-bit word indices, group 0 in bits 7:6 |
| v_i | input | K*32 | First source vector |
| w_i | input | K*32 | Second source vector |
| valid_o | output | 1 | Result valid |
| result_o | output | K*32 | Shuffled vector |
| err_o | output | 1 | Width code exceeded the quarter-vector limit |

## Verification
On every cycle, the assertions check that the output strobe lags the input strobe by exactly one cycle. They check that an error always comes with a zero result, that the error flag matches the width code captured one cycle earlier, and that result and flag stay stable on idle cycles. Only the bench's scenarios can show that each destination word holds the right bits. These are the word routing, the MSB-first field order, the per-group offset for the upper words and the worked example, all compared against a model of the requirements.

// File: rtl/vshuf.sv
module vshuf #(
  parameter int K = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_i,
  input  logic [1:0]      wcode_i,
  input  logic [3:0]      sel_i,
  input  logic [7:0]      idx_i,
  input  logic [K*32-1:0] v_i,
  input  logic [K*32-1:0] w_i,
  output logic            valid_o,
  output logic [K*32-1:0] result_o,
  output logic            err_o
);
  localparam int VW = K * 32;

  wire [3:0][VW-1:0] cand;
  wire               too_wide = (32'd1 << wcode_i) > 32'(K);

  for (genvar m = 0; m < 4; m++) begin : g_mode
    localparam int WB = 8 << m;
    localparam int NW = VW / WB;
    if ((1 << m) <= K) begin : g_ok
      for (genvar i = 0; i < NW; i++) begin : g_word
        localparam int G   = i % 4;
        localparam int OFF = i / 4;
        logic [31:0] src_word;
        assign src_word = 32'(idx_i[7-2*G -: 2]) + 32'(OFF);
        assign cand[m][i*WB +: WB] = sel_i[3-G] ? w_i[src_word*WB +: WB]
                                                : v_i[src_word*WB +: WB];
      end
    end else begin : g_off
      assign cand[m] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o  <= 1'b0;
      err_o    <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        err_o    <= too_wide;
        result_o <= too_wide ? '0 : cand[wcode_i];
      end
    end
  end
endmodule

// File: rtl/vshuf_chk.sv
module vshuf_chk #(
  parameter int K = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            valid_i,
  input logic [1:0]      wcode_i,
  input logic            valid_o,
  input logic [K*32-1:0] result_o,
  input logic            err_o
);
  a_r2_strobe_lag: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (valid_o == $past(valid_i)));

  a_r6_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (result_o == '0));

  a_r6_err_code: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && valid_o) |-> (err_o == ((32'd1 << $past(wcode_i)) > 32'(K))));

  a_r5_byte_ok: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && valid_o && $past(wcode_i) == 2'd0) |-> !err_o);

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(valid_i)) |-> ($stable(result_o) && $stable(err_o)));
endmodule

bind vshuf vshuf_chk #(.K(K)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .wcode_i(wcode_i),
  .valid_o(valid_o), .result_o(result_o), .err_o(err_o)
);

// File: tb/vshuf_test.sv
module vshuf_test;
  localparam int K   = 4;
  localparam int VW  = K * 32;
  localparam int CLK = 10;

  logic          clk = 0, rst_n = 0, valid_i = 0;
  logic [1:0]    wcode_i = 0;
  logic [3:0]    sel_i = 0;
  logic [7:0]    idx_i = 0;
  logic [VW-1:0] v_i = 0, w_i = 0;
  logic          valid_o, err_o;
  logic [VW-1:0] result_o;

  int total = 0, bad = 0;
  logic [VW-1:0] q_res[$];
  logic          q_err[$];
  string         q_tag[$];

  always #(CLK/2) clk = ~clk;

  vshuf #(.K(K)) uut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .wcode_i(wcode_i),
    .sel_i(sel_i), .idx_i(idx_i), .v_i(v_i), .w_i(w_i),
    .valid_o(valid_o), .result_o(result_o), .err_o(err_o)
  );

  function automatic logic [VW-1:0] model(input logic [1:0] wc, input logic [3:0] s,
                                          input logic [7:0] n, input logic [VW-1:0] v,
                                          input logic [VW-1:0] w);
    logic [VW-1:0] r = '0;
    int wb = 8 << wc;
    if ((1 << wc) > K) return '0;
    for (int i = 0; i < VW / wb; i++) begin
      int g = i % 4;
      int src = int'(n[7-2*g -: 2]) + i / 4;
      for (int b = 0; b < wb; b++)
        r[i*wb+b] = s[3-g] ? w[src*wb+b] : v[src*wb+b];
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] x;
    for (int i = 0; i < K; i++) x[i*32 +: 32] = $urandom;
    return x;
  endfunction

  task automatic check(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] wc, input logic [3:0] s, input logic [7:0] n,
                      input logic [VW-1:0] v, input logic [VW-1:0] w, input string tag);
    @(negedge clk);
    valid_i = 1; wcode_i = wc; sel_i = s; idx_i = n; v_i = v; w_i = w;
    q_res.push_back(model(wc, s, n, v, w));
    q_err.push_back((1 << wc) > K);
    q_tag.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    valid_i = 0;
  endtask

  logic prev_valid = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 strobe", {{(VW-1){1'b0}}, valid_o}, {{(VW-1){1'b0}}, prev_valid});
      if (valid_o) begin
        if (q_res.size() == 0) check("R2 unexpected result", 1, 0);
        else begin
          string t = q_tag.pop_front();
          check(t, result_o, q_res.pop_front());
          check({t, " R6 err"}, {{(VW-1){1'b0}}, err_o}, {{(VW-1){1'b0}}, q_err.pop_front()});
        end
      end
      prev_valid = valid_i;
    end
  end

  logic finished = 0;
  initial begin
    #(CLK * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] a, b, held;
    a = rnd_vec(); b = rnd_vec();
    #(CLK*2 + 2);
    check("R1 valid", {{(VW-1){1'b0}}, valid_o}, '0);
    check("R1 err", {{(VW-1){1'b0}}, err_o}, '0);
    check("R1 result", result_o, '0);
    @(negedge clk); rst_n = 1;

    // R8 worked example, low 64 bits compared directly
    send(2'd1, 4'b0011, 8'b10_11_01_10, a, b, "R8 example");
    idle();
    @(negedge clk);
    check("R8 low", {{(VW-64){1'b0}}, result_o[63:0]}, {{(VW-64){1'b0}}, b[47:16], a[63:32]});

    // R3 identity and all-w patterns, 32-bit words
    send(2'd2, 4'b0000, 8'b00_01_10_11, a, b, "R3 identity v");
    send(2'd2, 4'b1111, 8'b00_01_10_11, a, b, "R3 identity w");
    send(2'd2, 4'b1000, 8'b11_00_00_00, a, b, "R3 msb-first groups");
    // R4 offset of upper words, 8-bit and 16-bit
    send(2'd0, 4'b0000, 8'b00_00_00_00, a, b, "R4 byte offset");
    send(2'd1, 4'b0101, 8'b11_11_11_11, a, b, "R4 halfword offset");
    // R6 oversized width
    send(2'd3, 4'b1010, 8'h5a, a, b, "R6 too wide");
    // R5 every width code with random controls
    for (int i = 0; i < 40; i++)
      send(2'(i % 4), 4'($urandom), 8'($urandom), rnd_vec(), rnd_vec(), "R5 R3 R4 random");
    idle(); idle(); idle();

    // R7 hold while idle with other inputs toggling
    send(2'd0, 4'b0110, 8'h1e, a, b, "R7 setup");
    idle(); @(negedge clk);
    held = result_o;
    for (int i = 0; i < 3; i++) begin
      wcode_i = 2'(i); sel_i = 4'($urandom); idx_i = 8'($urandom);
      v_i = rnd_vec(); w_i = rnd_vec();
      @(negedge clk);
      check("R7 hold result", result_o, held);
    end
    send(2'd3, 4'd0, 8'd0, a, b, "R7 err setup");
    idle(); @(negedge clk);
    wcode_i = 2'd0;
    @(negedge clk);
    check("R7 hold err", {{(VW-1){1'b0}}, err_o}, {{(VW-1){1'b0}}, 1'b1});
    @(negedge clk);
    check("R7 queue drained", VW'(q_res.size()), '0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule